// File: doc/BRIEF.md
# DDS Tuning Word Load Interface

This block is the host-facing load path of a direct digital synthesizer. A host builds a 40-bit control and tuning word. It can send the word one byte at a time on a parallel bus, or one bit at a time on a serial line. Each rising edge of a word clock moves one unit into an input register. A rising edge of a separate update strobe then transfers the whole input register into the working registers. Those registers drive a downstream phase accumulator with a tuning word, a phase offset, a power-down flag and a reference-multiplier enable.

All host inputs are sampled on the system clock, and their rising edges are detected internally. After master reset the block starts in parallel mode. A special control byte, committed with the strobe, switches it to serial mode. Only a master reset switches it back.

Master reset returns the working registers and the mode to defaults. It deliberately keeps the 40-bit input register, so a word loaded before reset can still be committed after it. After reset is released, a short recovery window ignores host edges.

Top module: `dds_load_if`

## Requirements
- R1: While master reset is high, and after it until the next commit, the tuning word, phase offset, power-down flag, multiplier enable and serial-mode flag all read 0. The byte position returns to the control byte.
- R2: Master reset leaves the 40-bit input register unchanged. A strobe after recovery commits the word that was loaded before reset.
- R3: In parallel mode, each word-clock rising edge stores the bus byte at the current position and advances the position. The first byte is the control byte: bit 0 is the multiplier enable, bit 1 is the control flag, bit 2 is power-down, and bits 7..3 are the phase offset. The next four bytes form the tuning word, most significant byte first. Further bytes are ignored until the position returns to the control byte.
- R4: When the control flag is 0, an update-strobe rising edge copies the input register to the outputs. Every strobe returns the byte position to the control byte.
- R5: In parallel mode, committing a control byte whose low three bits are 011 sets the serial-mode flag and leaves the other outputs unchanged.
- R6: In serial mode, each word-clock rising edge shifts in one bit, and the last 40 bits form the word. They arrive as tuning word bits 0..31 (least significant first), then the multiplier enable, the control flag, power-down, and phase bits 0..4. Serial mode stays on until master reset.
- R7: A strobe is not committed when the control flag is 1. Apart from the R5 case, all outputs are left unchanged.
- R8: Committing power-down = 1 raises the power-down output, and committing power-down = 0 clears it.
- R9: For 2 system-clock cycles after reset falls, word-clock and strobe rising edges are ignored.
- R10: Master reset held for 5 system-clock cycles is enough to establish the R1 state. Shorter pulses are outside the block's contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Master reset, active high |
| wclk_i | input | 1 | Word clock; a rising edge loads a byte or a bit |
| fqud_i | input | 1 | Update strobe; a rising edge commits the input register |
| pdata_i | input | BUS_W | Parallel data byte |
| sdata_i | input | 1 | Serial data bit |
| ftw_o | output | FTW_W | Committed frequency tuning word |
| phase_o | output | BUS_W-3 | Committed phase offset |
| pdown_o | output | 1 | Power-down flag |
| mult_en_o | output | 1 | Reference clock multiplier enable |
| serial_o | output | 1 | Serial load mode active |

## Verification
The assertions assume that master reset stays high for at least five system clocks. They also assume that the word clock and the update strobe never rise in the same cycle, and that every level of a host input lasts at least one system clock. Data must be valid in the cycle where the word-clock edge is seen. The stimulus tasks hold each host level for a full clock and finish one word-clock pulse before starting a strobe. Their reset pulses are five and six cycles long. The only edges placed inside the recovery window are the ones that R9 expects to be dropped.

// File: rtl/dds_load_pkg.sv
package dds_load_pkg;
   // control byte field positions
   localparam int CTL_MULT_BIT = 0;
   localparam int CTL_FLAG_BIT = 1;
   localparam int CTL_PD_BIT   = 2;
   localparam int CTL_PH_LSB   = 3;
   localparam logic [2:0] SER_ENTRY_CODE = 3'b011;

   function automatic logic is_ser_entry(input logic [2:0] low_bits);
      return low_bits == SER_ENTRY_CODE;
   endfunction
endpackage

// File: rtl/dds_edge_det.sv
module dds_edge_det (
   input  logic clk_i,
   input  logic sig_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk_i) prev_q <= sig_i;

   assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/dds_reset_ctl.sv
module dds_reset_ctl #(
   parameter int RST_MIN = 5,
   parameter int RECOV   = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic hold_o
);
   localparam int CW = $clog2(RECOV + 1);
   localparam int RW = $clog2(RST_MIN + 1);

   if (RECOV < 1) begin : g_bad_recov
      $error("RECOV must be at least 1");
   end
   if (RST_MIN < 1) begin : g_bad_min
      $error("RST_MIN must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [RW-1:0] run_q;
   logic          rst_q;

   always_ff @(posedge clk_i) begin
      // R10
      if (!rst_i && rst_q) begin
         rst_width_chk: assert (run_q >= RW'(RST_MIN));
      end
      rst_q <= rst_i;
      if (rst_i) begin
         cnt_q <= CW'(RECOV);
         if (run_q < RW'(RST_MIN)) run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign hold_o = rst_i | (cnt_q != '0);

   // R9
   recov_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> hold_o);
endmodule

// File: rtl/dds_word_asm.sv
module dds_word_asm #(
   parameter int BUS_W  = 8,
   parameter int NBYTES = 5
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    hold_i,
   input  logic                    ser_i,
   input  logic                    wr_i,
   input  logic                    clr_i,
   input  logic [BUS_W-1:0]        pdata_i,
   input  logic                    sdata_i,
   output logic [BUS_W*NBYTES-1:0] word_o
);
   localparam int PW = $clog2(NBYTES + 1);

   logic [PW-1:0] ptr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ptr_q <= '0;
      end else if (!hold_i) begin
         if (clr_i) ptr_q <= '0;
         else if (wr_i && !ser_i && ptr_q < PW'(NBYTES)) ptr_q <= ptr_q + 1'b1;
      end
   end

   // lane 0 holds the control byte; serial bits enter at its top
   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      logic [BUS_W-1:0] lane_q;
      logic             in_bit;
      if (g == 0) begin : g_head
         assign in_bit = sdata_i;
      end else begin : g_chain
         assign in_bit = word_o[BUS_W*(NBYTES-g)];
      end
      always_ff @(posedge clk_i) begin
         if (!hold_i && wr_i) begin
            if (ser_i) lane_q <= {in_bit, lane_q[BUS_W-1:1]};
            else if (ptr_q == PW'(g)) lane_q <= pdata_i;
         end
      end
      assign word_o[BUS_W*(NBYTES-g)-1 -: BUS_W] = lane_q;
   end

   // R3
   ptr_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ptr_q <= PW'(NBYTES));
   // R6
   ser_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (ser_i && !clr_i) |=> $stable(ptr_q));
endmodule

// File: rtl/dds_load_if.sv
module dds_load_if
   import dds_load_pkg::*;
#(
   parameter int FTW_W   = 32,
   parameter int BUS_W   = 8,
   parameter int RST_MIN = 5,
   parameter int RECOV   = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             wclk_i,
   input  logic             fqud_i,
   input  logic [BUS_W-1:0] pdata_i,
   input  logic             sdata_i,
   output logic [FTW_W-1:0] ftw_o,
   output logic [BUS_W-4:0] phase_o,
   output logic             pdown_o,
   output logic             mult_en_o,
   output logic             serial_o
);
   localparam int NBYTES = FTW_W / BUS_W + 1;
   localparam int WORD_W = NBYTES * BUS_W;

   if (FTW_W % BUS_W != 0) begin : g_bad_width
      $error("FTW_W must be a multiple of BUS_W");
   end
   if (BUS_W < 4) begin : g_bad_bus
      $error("BUS_W must leave room for a phase field");
   end

   logic              hold_w, wr_w, fq_w;
   logic [WORD_W-1:0] word_w;
   logic [BUS_W-1:0]  ctl_w;

   dds_reset_ctl #(.RST_MIN(RST_MIN), .RECOV(RECOV)) rst_ctl_i (
      .clk_i(clk_i), .rst_i(rst_i), .hold_o(hold_w));

   dds_edge_det wclk_det_i (.clk_i(clk_i), .sig_i(wclk_i), .rise_o(wr_w));
   dds_edge_det fqud_det_i (.clk_i(clk_i), .sig_i(fqud_i), .rise_o(fq_w));

   dds_word_asm #(.BUS_W(BUS_W), .NBYTES(NBYTES)) asm_i (
      .clk_i(clk_i), .rst_i(rst_i), .hold_i(hold_w), .ser_i(serial_o),
      .wr_i(wr_w), .clr_i(fq_w), .pdata_i(pdata_i), .sdata_i(sdata_i),
      .word_o(word_w));

   assign ctl_w = word_w[WORD_W-1 -: BUS_W];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ftw_o     <= '0;
         phase_o   <= '0;
         pdown_o   <= 1'b0;
         mult_en_o <= 1'b0;
         serial_o  <= 1'b0;
      end else if (!hold_w && fq_w) begin
         if (!ctl_w[CTL_FLAG_BIT]) begin
            ftw_o     <= word_w[FTW_W-1:0];
            phase_o   <= ctl_w[BUS_W-1:CTL_PH_LSB];
            pdown_o   <= ctl_w[CTL_PD_BIT];
            mult_en_o <= ctl_w[CTL_MULT_BIT];
         end else if (!serial_o && is_ser_entry(ctl_w[2:0])) begin
            serial_o <= 1'b1;
         end
      end
   end

   logic rst_seen_q;
   always_ff @(posedge clk_i) begin
      // R1
      if (rst_seen_q) begin
         rst_defaults_chk: assert (ftw_o == '0 && phase_o == '0 && !pdown_o
                                   && !mult_en_o && !serial_o);
      end
      rst_seen_q <= rst_i;
   end

   // R7
   flag_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (fq_w && ctl_w[CTL_FLAG_BIT]) |=> ($stable(ftw_o) && $stable(phase_o)
                                         && $stable(pdown_o) && $stable(mult_en_o)));
   // R5
   ser_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (fq_w && !hold_w && ctl_w[2:0] == 3'b011) |=> serial_o);
   // R9
   recov_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      hold_w |=> ($stable(ftw_o) && $stable(serial_o) && $stable(pdown_o)));
   // R6
   serial_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      serial_o |=> serial_o);
endmodule

// File: tb/dds_load_if_tb_top.sv
`timescale 1ns/1ps
module dds_load_if_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wclk = 1'b0, fqud = 1'b0, sdata = 1'b0;
   logic [7:0]  pdata = 8'h00;
   logic [31:0] ftw;
   logic [4:0]  phase;
   logic        pdown, mult_en, serial;

   int    checks = 0, errors = 0, cyc = 0;
   bit    started = 0, done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   dds_load_if dut_i (
      .clk_i(clk), .rst_i(rst), .wclk_i(wclk), .fqud_i(fqud),
      .pdata_i(pdata), .sdata_i(sdata), .ftw_o(ftw), .phase_o(phase),
      .pdown_o(pdown), .mult_en_o(mult_en), .serial_o(serial));

   // behavioural reference model
   logic [39:0] m_word = '0;
   int          m_ptr = 0, m_rec = 0;
   bit          m_ser = 0, m_pd = 0, m_mul = 0, m_pw = 0, m_pf = 0;
   logic [31:0] m_ftw = '0;
   logic [4:0]  m_ph = '0;

   always @(posedge clk) begin
      bit we, fe;
      we = wclk && !m_pw;
      fe = fqud && !m_pf;
      m_pw = wclk;
      m_pf = fqud;
      if (rst) begin
         m_ser = 0; m_ptr = 0; m_ftw = '0; m_ph = '0; m_pd = 0; m_mul = 0; m_rec = 2;
      end else if (m_rec > 0) begin
         m_rec--;
      end else begin
         if (fe) begin
            if (!m_word[33]) begin
               m_ftw = m_word[31:0]; m_ph = m_word[39:35];
               m_pd = m_word[34];    m_mul = m_word[32];
            end else if (!m_ser && m_word[34:32] == 3'b011) begin
               m_ser = 1;
            end
            m_ptr = 0;
         end
         if (we) begin
            if (m_ser) m_word = {sdata, m_word[39:1]};
            else if (m_ptr < 5) begin
               m_word[39-8*m_ptr -: 8] = pdata;
               m_ptr++;
            end
         end
      end
      cyc++;
      started <= 1;
   end

   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (ftw !== m_ftw || phase !== m_ph || pdown !== m_pd
             || mult_en !== m_mul || serial !== m_ser) begin
            errors++;
            $display("FAIL %s cycle %0d: got ftw=%h ph=%h pd=%b mul=%b ser=%b expected ftw=%h ph=%h pd=%b mul=%b ser=%b",
                     cur_req, cyc, ftw, phase, pdown, mult_en, serial,
                     m_ftw, m_ph, m_pd, m_mul, m_ser);
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk); pdata = b; wclk = 1'b1;
      @(negedge clk); wclk = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); fqud = 1'b1;
      @(negedge clk); fqud = 1'b0;
   endtask

   task automatic put_word(input logic [7:0] w0, input logic [31:0] f);
      put_byte(w0);
      put_byte(f[31:24]); put_byte(f[23:16]); put_byte(f[15:8]); put_byte(f[7:0]);
   endtask

   task automatic put_serial(input logic [39:0] w);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); sdata = w[i]; wclk = 1'b1;
         @(negedge clk); wclk = 1'b0;
      end
   endtask

   function automatic logic [7:0] ctl(input logic [4:0] ph, input bit pd, input bit fl, input bit mul);
      return {ph, pd, fl, mul};
   endfunction

   task automatic summary();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: got cycle %0d expected completion", cyc);
         summary();
      end
   end

   initial begin
      // R10 / R1: six-cycle reset from time zero
      cur_req = "R1";
      repeat (6) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 ftw", 64'(ftw), 64'h0);
      chk("R1 serial", 64'(serial), 64'h0);
      chk("R1 pdown/mult", 64'({pdown, mult_en}), 64'h0);

      cur_req = "R3";
      put_word(ctl(5'h13, 0, 0, 1), 32'h12345678);
      cur_req = "R4";
      strobe();
      chk("R4 ftw", 64'(ftw), 64'h12345678);
      chk("R3 phase", 64'(phase), 64'h13);
      chk("R3 mult", 64'(mult_en), 64'h1);

      cur_req = "R3";
      put_word(ctl(5'h05, 0, 0, 0), 32'hAABBCCDD);
      put_byte(8'hEE);
      strobe();
      chk("R3 extra byte ignored", 64'(ftw), 64'hAABBCCDD);

      cur_req = "R4";
      put_byte(ctl(5'h01, 0, 0, 0));
      put_byte(8'h11);
      strobe();
      chk("R4 partial commit", 64'(ftw), 64'h11BBCCDD);
      chk("R4 partial phase", 64'(phase), 64'h01);
      put_word(ctl(5'h02, 0, 0, 0), 32'h01020304);
      strobe();
      chk("R4 pointer back at W0", 64'(ftw), 64'h01020304);

      cur_req = "R8";
      put_byte(ctl(5'h00, 1, 0, 0));
      strobe();
      chk("R8 power-down on", 64'(pdown), 64'h1);
      put_byte(ctl(5'h00, 0, 0, 0));
      strobe();
      chk("R8 power-down off", 64'(pdown), 64'h0);

      // R2 and R9: load, reset for exactly five cycles, edges in recovery window
      cur_req = "R2";
      put_word(ctl(5'h1F, 0, 0, 1), 32'hCAFEF00D);
      cur_req = "R10";
      @(negedge clk); rst = 1'b1;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      cur_req = "R9";
      pdata = 8'h55; wclk = 1'b1;
      @(negedge clk); wclk = 1'b0; fqud = 1'b1;
      @(negedge clk); fqud = 1'b0;
      @(negedge clk);
      chk("R9 strobe in window ignored", 64'(ftw), 64'h0);
      chk("R10 reset defaults", 64'({phase, pdown, mult_en, serial}), 64'h0);
      cur_req = "R2";
      strobe();
      chk("R2 word survived reset", 64'(ftw), 64'hCAFEF00D);
      chk("R2 control survived reset", 64'(phase), 64'h1F);

      cur_req = "R7";
      put_byte(ctl(5'h00, 1, 1, 0));
      strobe();
      chk("R7 flagged word held", 64'(ftw), 64'hCAFEF00D);
      chk("R7 no serial entry", 64'(serial), 64'h0);

      cur_req = "R5";
      put_byte(8'h03);
      strobe();
      chk("R5 serial entered", 64'(serial), 64'h1);
      chk("R5 outputs held", 64'(ftw), 64'hCAFEF00D);

      cur_req = "R6";
      put_serial({ctl(5'h0A, 1, 0, 0), 32'h0BADBEEF});
      strobe();
      chk("R6 serial ftw", 64'(ftw), 64'h0BADBEEF);
      chk("R6 serial pd/ph", 64'({phase, pdown}), 64'({5'h0A, 1'b1}));

      cur_req = "R7";
      put_serial({ctl(5'h00, 0, 1, 0), 32'h11111111});
      strobe();
      chk("R7 serial W33 blocks", 64'(ftw), 64'h0BADBEEF);

      cur_req = "R6";
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); sdata = 1'b1; wclk = 1'b1;
         @(negedge clk); wclk = 1'b0;
      end
      put_serial({ctl(5'h03, 0, 0, 1), 32'h76543210});
      strobe();
      chk("R6 last 40 bits", 64'(ftw), 64'h76543210);
      chk("R6 mult", 64'(mult_en), 64'h1);

      cur_req = "R1";
      @(negedge clk); rst = 1'b1;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 back to parallel", 64'(serial), 64'h0);
      put_word(ctl(5'h04, 0, 0, 0), 32'h00C0FFEE);
      strobe();
      chk("R1 pointer at W0 after reset", 64'(ftw), 64'h00C0FFEE);

      repeat (2) @(negedge clk);
      summary();
   end
endmodule